// File: doc/BRIEF.md
# Serial Configuration Loader with Control-Bit Routing

This block receives configuration words for a frequency synthesizer over a three-wire serial port made of a serial clock, a serial data line and a load strobe. All three wires arrive already synchronized to the block's system clock. On each rising edge of the serial clock, one data bit moves into a 19-bit shift register. The most significant bit is sent first, so the last bit sent always ends up in the lowest position. That last bit is the routing bit.

When the load strobe rises, the routing bit picks one of two register sets, and that set takes the current word. A routing bit of 1 selects the reference set. It holds a 14-bit reference division ratio and four single-bit options: prescaler modulus, phase polarity, monitor-output choice and pump-current level. A routing bit of 0 selects the divider set. It holds a 7-bit swallow value and an 11-bit main count.

The set that is not selected keeps its contents. A reference word whose ratio is below 3 is rejected, so the reference set never holds a prohibited ratio. The latched fields drive the rest of the synthesizer directly.

Top module: `serial_cfg_loader`

## Requirements
- R1: One bit is captured for each rising edge seen on `ser_clk` while `ser_load` is low. The bit is captured however many system clocks the serial clock stays high or low.
- R2: The first bit sent becomes word bit 18 and the last bit sent becomes word bit 0. Word bit 0 is the routing bit.
- R3: With routing bit 1, the reference set loads from these word bits: ratio = bits 14..1 (bit 1 is the LSB), `presc_small` = bit 15, `pol_pos` = bit 16, `mon_freq` = bit 17, `pump_high` = bit 18.
- R4: With routing bit 0, the divider set loads from these word bits: `swallow` = bits 7..1 (bit 1 is the LSB) and `main_div` = bits 18..8 (bit 8 is the LSB).
- R5: The latched outputs change only when a rising edge of `ser_load` is seen. Holding `ser_load` high causes no further loads.
- R6: The set not selected by the routing bit keeps its previous contents across a load.
- R7: Serial clock edges that occur while `ser_load` is high are ignored and leave the shift register unchanged.
- R8: A load uses the 19 most recent bits, however many extra bits came before them.
- R9: A reference word whose ratio is below 3 is discarded as a whole, and the reference set keeps its previous contents.
- R10: Reset (`rst_n` low) sets the outputs to: ratio 3, `presc_small` 1 (64/65 modulus), `pol_pos` 1, `mon_freq` 0 (lock-detect monitor), `pump_high` 0 (low current), swallow 0, main count 3.
- R11: Updated outputs appear at the first system clock edge at which `ser_load` is sampled high after having been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock, synchronized to `clk` |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, active on its rising edge |
| ref_ratio | output | 14 | Reference division ratio |
| presc_small | output | 1 | 1: 64/65 prescaler, 0: 128/129 |
| pol_pos | output | 1 | Phase comparator polarity |
| mon_freq | output | 1 | 1: frequency monitor output, 0: lock detect |
| pump_high | output | 1 | 1: high pump current, 0: low |
| swallow | output | 7 | Swallow counter value |
| main_div | output | 11 | Main counter value |

## Verification
The hardest situation to reach from the ports is a load strobe that lands on a shift register that has been disturbed. The disturbance can be surplus leading bits, serial clock edges sent while the strobe is high, or a serial clock held high across many system clocks.

The stimulus creates each case on purpose. It sends junk bits ahead of a frame. It toggles the serial clock with all-ones data while the strobe is held high, then fires a second strobe with no new bits, so any leaked shift would show up as a flipped routing bit. It stretches each serial clock phase to ten system clocks. A behavioural bit-queue model checks every output on every cycle.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int FRAME_W = 19;
  localparam int RATIO_W = 14;
  localparam int SWAL_W  = 7;
  localparam int MAIN_W  = 11;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               presc_small;
    logic               pol_pos;
    logic               mon_freq;
    logic               pump_high;
  } ref_set_t;

  typedef struct packed {
    logic [SWAL_W-1:0] swallow;
    logic [MAIN_W-1:0] main_div;
  } div_set_t;
endpackage

// File: rtl/scl_rise_det.sv
module scl_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/scl_shift.sv
module scl_shift #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/scl_bank.sv
module scl_bank
  import scl_pkg::*;
#(
  parameter int RATIO_MIN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  output ref_set_t           ref_q,
  output div_set_t           div_q
);
  localparam int RATIO_LO = 1;
  localparam int RATIO_HI = RATIO_LO + RATIO_W - 1;
  localparam int OPT_LO   = RATIO_HI + 1;
  localparam int SWAL_LO  = 1;
  localparam int SWAL_HI  = SWAL_LO + SWAL_W - 1;
  localparam int MAIN_LO  = SWAL_HI + 1;
  localparam int MAIN_HI  = MAIN_LO + MAIN_W - 1;

  ref_set_t ref_d;
  div_set_t div_d;
  logic     to_ref;
  logic     ratio_ok;

  always_comb begin
    to_ref            = word[0];
    ref_d.ratio       = word[RATIO_HI:RATIO_LO];
    ref_d.presc_small = word[OPT_LO];
    ref_d.pol_pos     = word[OPT_LO+1];
    ref_d.mon_freq    = word[OPT_LO+2];
    ref_d.pump_high   = word[OPT_LO+3];
    div_d.swallow     = word[SWAL_HI:SWAL_LO];
    div_d.main_div    = word[MAIN_HI:MAIN_LO];
    ratio_ok          = (32'(ref_d.ratio) >= RATIO_MIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= '{ratio: RATIO_W'(RATIO_MIN), presc_small: 1'b1, pol_pos: 1'b1,
                 mon_freq: 1'b0, pump_high: 1'b0};
      div_q <= '{swallow: '0, main_div: MAIN_W'(3)};
    end else if (load) begin
      if (to_ref && ratio_ok) ref_q <= ref_d;
      if (!to_ref)            div_q <= div_d;
    end
  end

  AST_REF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ref_q.ratio) >= RATIO_MIN); // R9
  AST_DIV_KEEP_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word[0]) |=> $stable(div_q)); // R6
  AST_REF_KEEP_ON_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !word[0]) |=> $stable(ref_q)); // R6
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import scl_pkg::*;
#(
  parameter int RATIO_MIN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_load,
  output logic [RATIO_W-1:0] ref_ratio,
  output logic               presc_small,
  output logic               pol_pos,
  output logic               mon_freq,
  output logic               pump_high,
  output logic [SWAL_W-1:0]  swallow,
  output logic [MAIN_W-1:0]  main_div
);
  logic [1:0]         rise;
  logic               sclk_rise;
  logic               load_rise;
  logic               shift_en;
  logic [FRAME_W-1:0] word;
  ref_set_t           ref_q;
  div_set_t           div_q;

  scl_rise_det #(.N(2)) u_rise (
    .clk (clk),
    .rst_n (rst_n),
    .lvl ({ser_load, ser_clk}),
    .rise (rise)
  );
  assign sclk_rise = rise[0];
  assign load_rise = rise[1];
  assign shift_en  = sclk_rise & ~ser_load;

  scl_shift #(.W(FRAME_W)) u_shift (
    .clk (clk),
    .rst_n (rst_n),
    .shift_en (shift_en),
    .din (ser_data),
    .word (word)
  );

  scl_bank #(.RATIO_MIN(RATIO_MIN)) u_bank (
    .clk (clk),
    .rst_n (rst_n),
    .load (load_rise),
    .word (word),
    .ref_q (ref_q),
    .div_q (div_q)
  );

  assign ref_ratio   = ref_q.ratio;
  assign presc_small = ref_q.presc_small;
  assign pol_pos     = ref_q.pol_pos;
  assign mon_freq    = ref_q.mon_freq;
  assign pump_high   = ref_q.pump_high;
  assign swallow     = div_q.swallow;
  assign main_div    = div_q.main_div;

  AST_NO_SHIFT_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |=> $stable(word)); // R7
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> ($stable(ref_q) && $stable(div_q))); // R5
  AST_ONE_BIT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[FRAME_W-1:1] == $past(word[FRAME_W-2:0]))); // R1
endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [13:0] ref_ratio;
  logic presc_small, pol_pos, mon_freq, pump_high;
  logic [6:0] swallow;
  logic [10:0] main_div;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_loader dut_i (
    .clk (clk), .rst_n (rst_n), .ser_clk (ser_clk), .ser_data (ser_data),
    .ser_load (ser_load), .ref_ratio (ref_ratio), .presc_small (presc_small),
    .pol_pos (pol_pos), .mon_freq (mon_freq), .pump_high (pump_high),
    .swallow (swallow), .main_div (main_div)
  );

  // behavioural reference model
  bit q[$];
  int m_ratio, m_ps, m_pol, m_mon, m_pump, m_swal, m_main;
  bit prev_sclk, prev_load;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_ratio = 3; m_ps = 1; m_pol = 1; m_mon = 0; m_pump = 0;
      m_swal = 0; m_main = 3;
      prev_sclk = 0; prev_load = 0;
    end else begin
      if (ser_load && !prev_load) begin
        int f;
        f = 0;
        for (int i = 0; i < 19 - q.size(); i++) f = f << 1;
        foreach (q[i]) f = (f << 1) | int'(q[i]);
        if (f % 2 == 1) begin
          if (((f >> 1) & 16'h3FFF) >= 3) begin
            m_ratio = (f >> 1) & 16'h3FFF;
            m_ps = (f >> 15) & 1; m_pol = (f >> 16) & 1;
            m_mon = (f >> 17) & 1; m_pump = (f >> 18) & 1;
          end
        end else begin
          m_swal = (f >> 1) & 127;
          m_main = (f >> 8) & 2047;
        end
      end
      if (ser_clk && !prev_sclk && !ser_load) begin
        q.push_back(ser_data);
        if (q.size() > 19) void'(q.pop_front());
      end
      prev_sclk = ser_clk;
      prev_load = ser_load;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 ratio", ref_ratio, m_ratio);
      check("R3 opts", {presc_small, pol_pos, mon_freq, pump_high},
            (m_ps << 3) | (m_pol << 2) | (m_mon << 1) | m_pump);
      check("R4 swallow", swallow, m_swal);
      check("R4 main", main_div, m_main);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] w, int nbits, int hold);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i]; ser_clk = 1'b0;
      idle(hold);
      ser_clk = 1'b1;
      idle(hold);
    end
    @(negedge clk); ser_clk = 1'b0;
  endtask

  task automatic strobe(int len);
    @(negedge clk); ser_load = 1'b1;
    idle(len);
    ser_load = 1'b0;
    idle(2);
  endtask

  function automatic logic [18:0] ref_word(int r, bit ps, bit pol, bit mon, bit pump);
    return {pump, mon, pol, ps, 14'(r), 1'b1};
  endfunction

  function automatic logic [18:0] div_word(int a, int n);
    return {11'(n), 7'(a), 1'b0};
  endfunction

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset defaults
    check("R10 ratio", ref_ratio, 3);
    check("R10 presc", presc_small, 1);
    check("R10 pol", pol_pos, 1);
    check("R10 mon", mon_freq, 0);
    check("R10 pump", pump_high, 0);
    check("R10 swallow", swallow, 0);
    check("R10 main", main_div, 3);

    // R2/R3 reference load
    send_bits(32'(ref_word(1000, 0, 0, 1, 1)), 19, 1);
    check("R5 no change before strobe", ref_ratio, 3);
    // R11: load seen at the first edge with strobe high
    @(negedge clk); ser_load = 1'b1;
    @(negedge clk);
    check("R11 ratio after one edge", ref_ratio, 1000);
    check("R3 presc", presc_small, 0);
    check("R3 pump", pump_high, 1);
    check("R6 divider kept", main_div, 3);
    idle(5); ser_load = 1'b0; idle(2);
    check("R5 held strobe no reload", ref_ratio, 1000);

    // R4 divider load
    send_bits(32'(div_word(45, 1234)), 19, 1);
    strobe(2);
    check("R4 swallow", swallow, 45);
    check("R4 main", main_div, 1234);
    check("R6 reference kept", ref_ratio, 1000);

    // R7 shifts while strobe high ignored: reload same divider word
    @(negedge clk); ser_load = 1'b1; ser_data = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
    ser_load = 1'b0; idle(2);
    strobe(1);
    check("R7 ref untouched", ref_ratio, 1000);
    check("R7 main same", main_div, 1234);

    // R8 extra leading bits
    send_bits(32'h2B, 6, 1);
    send_bits(32'(div_word(127, 2047)), 19, 1);
    strobe(1);
    check("R8 swallow", swallow, 127);
    check("R8 main", main_div, 2047);

    // R9 prohibited ratio rejected, boundary 3 accepted
    send_bits(32'(ref_word(2, 1, 1, 0, 0)), 19, 1);
    strobe(1);
    check("R9 ratio 2 rejected", ref_ratio, 1000);
    check("R9 opts kept", pump_high, 1);
    send_bits(32'(ref_word(3, 1, 0, 0, 0)), 19, 1);
    strobe(1);
    check("R9 ratio 3 accepted", ref_ratio, 3);

    // R1 slow serial clock, maximum ratio
    send_bits(32'(ref_word(16383, 1, 1, 1, 0)), 19, 10);
    strobe(1);
    check("R1 slow clock ratio", ref_ratio, 16383);
    check("R1 slow clock mon", mon_freq, 1);
    check("R1 slow clock pump", pump_high, 0);

    idle(3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule